// File: doc/BRIEF.md
# Charge-Transfer Capacitive Acquisition Sequencer

This block runs a charge-transfer capacitive touch measurement over a set of sensor groups. After a start request it produces a train of charge-transfer pulses. Each pulse is a high (charge) phase followed by a low (transfer) phase, and both phase lengths are counted in ticks of a divided clock. At the end of every pulse, each enabled group that has not yet finished increments its own pulse counter. A group finishes at the first pulse end where its comparator input is high. That comparator input is already synchronous and digital, one bit per group.

The acquisition ends in one of two ways. It ends normally when every enabled group has finished. It ends in error when any group's counter reaches the selected maximum count before its comparator trips. The sequencer then raises an end-of-acquisition flag and drops its start bit. Each of the two flags has its own interrupt enable and its own write-one-to-clear bit. Acquisition can begin directly from the start request, or it can wait for a qualifying event on a sync input.

All configuration and status pins are plain levels. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Configuration is expected to stay stable while `busy` is high.

Top module: `cap_acq_seq`

## Requirements
- R1: The high phase of every pulse lasts (hi_len+1)·2^pg_div clock cycles, with `ch_level` high throughout. hi_len is 4 bits and holds the count minus one.
- R2: The low phase of every pulse lasts (lo_len+1)·2^pg_div clock cycles, with `ch_level` low. lo_len is 4 bits and holds the count minus one.
- R3: When group g finishes, its count equals the number of the pulse at whose end `cmp_in[g]` was first high. The count then stays frozen until the next acquisition launches, and launching clears every count and every done bit.
- R4: The maximum count is 2^(8+max_code)−1. Codes 7 and above behave like code 6, giving 16383. If a group's count reaches that limit at a pulse end while its comparator is low, `mce_flag` sets and the whole acquisition ends.
- R5: With sync_mode=0, a set start bit launches at once. With sync_mode=1 the block waits. With sync_pol=0 it waits for a falling edge of `sync_in` only, so a rising edge or a high level does not launch. With sync_pol=1 a high level of `sync_in` launches.
- R6: One cycle after the last enabled group finishes, or one cycle after a max-count error, `eoa_flag` sets and `busy` (the start bit) clears.
- R7: In the same cycle, `flag_clr[0]` clears `eoa_flag` and `flag_clr[1]` clears `mce_flag`. Each bit acts only on its own flag. A flag set in that same cycle wins over its clear.
- R8: `irq` is high exactly when (eoa_flag AND eoa_ie) OR (mce_flag AND mce_ie).
- R9: Bit g of `grp_done` reads 1 only if group g finished and `mce_flag` is clear.
- R10: While no pulse train runs, `ch_level` is 0 and `ch_oe` equals NOT idle_float: idle_float=0 drives low, idle_float=1 floats. During a pulse train `ch_oe` is 1.
- R11: Dropping `en` aborts at once and clears `busy`. `start_set` has no effect while `en` is low.
- R12: Disabled groups keep count 0 and done 0. An acquisition launched with no group enabled ends without any pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low aborts |
| start_set | input | 1 | One-cycle request to set the start bit |
| hi_len | input | 4 | High phase length minus one, in divided ticks |
| lo_len | input | 4 | Low phase length minus one, in divided ticks |
| pg_div | input | 3 | Divider exponent: tick every 2^pg_div clocks |
| max_code | input | 3 | Maximum-count code |
| sync_mode | input | 1 | 1: wait for a sync event before launching |
| sync_pol | input | 1 | 0: falling edge; 1: high level |
| sync_in | input | 1 | Synchronous sync input |
| idle_float | input | 1 | Idle IO mode: 0 drive low, 1 float |
| eoa_ie | input | 1 | End-of-acquisition interrupt enable |
| mce_ie | input | 1 | Max-count error interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 eoa, bit 1 mce |
| grp_en | input | NG | Group enable mask |
| cmp_in | input | NG | Per-group comparator, synchronous |
| busy | output | 1 | Start bit; high from request to end |
| ch_level | output | 1 | Channel drive level (high phase) |
| ch_oe | output | 1 | Channel output enable |
| eoa_flag | output | 1 | End-of-acquisition flag |
| mce_flag | output | 1 | Max-count error flag |
| irq | output | 1 | Interrupt request |
| grp_done | output | NG | Per-group successful completion |
| grp_count | output | NG*CW | Per-group pulse counts, group g at bits [g*CW +: CW] |

## Verification
The assertions assume that grp_en, the phase lengths, the divider and the count code stay fixed from launch until `busy` falls. They also assume that `cmp_in` and `sync_in` change only synchronously to the clock, and that `en` stays high through an acquisition except where an abort is intended. The bench meets these assumptions by changing configuration only while the block is idle, and by driving every input on the falling clock edge. It also derives each comparator level from the pulses it has itself counted on `ch_level`. This makes the trip point of each group an exact pulse number.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/cts_prescaler.sv
// Divided-clock tick generator: one tick every 2^div cycles while running.
module cts_prescaler #(
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  localparam int PW = (1 << DIVW) - 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  assign mask = PW'((PW+1)'(1) << div) - PW'(1);
  assign tick = run && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + PW'(1);
    else          cnt_q <= '0;
  end
endmodule

// File: rtl/cts_group_ctr.sv
// Per-group pulse counter with completion bit.
module cts_group_ctr #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          grp_on,
  input  logic          cmp,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          active;

  assign active = grp_on && !done_q;
  assign hit    = active && !cmp && ((cnt_q + CW'(1)) == limit);
  assign cnt    = cnt_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (step && active) begin
      cnt_q <= cnt_q + CW'(1);
      if (cmp) done_q <= 1'b1;
    end
  end

  // R3: a finished group holds its count until the next launch
  p_cnt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/cts_phase_ctrl.sv
// Start bit, sync qualification and high/low phase sequencing.
module cts_phase_ctrl
  import cts_pkg::*;
#(
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start_set,
  input  logic            sync_mode,
  input  logic            sync_pol,
  input  logic            sync_in,
  input  logic            tick,
  input  logic [LENW-1:0] hi_len,
  input  logic [LENW-1:0] lo_len,
  input  logic            no_groups,
  input  logic            finish_cond,
  output logic            start_q,
  output logic            running,
  output logic            in_high,
  output logic            launch,
  output logic            pulse_end,
  output logic            finishing
);
  seq_state_t      state_q;
  logic [LENW-1:0] ph_q;
  logic            sync_q;
  logic            sync_hit;
  logic            phase_last;

  assign sync_hit   = sync_pol ? sync_in : (sync_q && !sync_in);
  assign launch     = en && start_q &&
                      (((state_q == ST_IDLE) && !sync_mode) ||
                       ((state_q == ST_WAIT) && sync_hit));
  assign in_high    = (state_q == ST_HIGH);
  assign running    = (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign phase_last = tick && (ph_q == (in_high ? hi_len : lo_len));
  assign pulse_end  = (state_q == ST_LOW) && phase_last;
  assign finishing  = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      start_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (!en) begin
        state_q <= ST_IDLE;
        ph_q    <= '0;
        start_q <= 1'b0;
      end else begin
        if (start_set) start_q <= 1'b1;
        unique case (state_q)
          ST_IDLE: begin
            ph_q <= '0;
            if (start_q) begin
              if (launch) state_q <= no_groups ? ST_FIN : ST_HIGH;
              else        state_q <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            ph_q <= '0;
            if (launch) state_q <= no_groups ? ST_FIN : ST_HIGH;
          end
          ST_HIGH: begin
            if (phase_last) begin
              ph_q    <= '0;
              state_q <= ST_LOW;
            end else if (tick) ph_q <= ph_q + LENW'(1);
          end
          ST_LOW: begin
            if (phase_last) begin
              ph_q    <= '0;
              state_q <= finish_cond ? ST_FIN : ST_HIGH;
            end else if (tick) ph_q <= ph_q + LENW'(1);
          end
          ST_FIN: begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: in level-sync mode a pulse train only begins after sync_in was high
  p_sync_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_high) && sync_mode && sync_pol && $past(state_q == ST_WAIT))
      |-> $past(sync_in));

  // R6: the finishing cycle always drops the start bit
  p_fin_drops_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finishing |=> !start_q);
endmodule

// File: rtl/cap_acq_seq.sv
module cap_acq_seq #(
  parameter int NG        = 4,
  parameter int LENW      = 4,
  parameter int DIVW      = 3,
  parameter int CODEW     = 3,
  parameter int MCODE_MAX = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start_set,
  input  logic [LENW-1:0]    hi_len,
  input  logic [LENW-1:0]    lo_len,
  input  logic [DIVW-1:0]    pg_div,
  input  logic [CODEW-1:0]   max_code,
  input  logic               sync_mode,
  input  logic               sync_pol,
  input  logic               sync_in,
  input  logic               idle_float,
  input  logic               eoa_ie,
  input  logic               mce_ie,
  input  logic [1:0]         flag_clr,
  input  logic [NG-1:0]      grp_en,
  input  logic [NG-1:0]      cmp_in,
  output logic               busy,
  output logic               ch_level,
  output logic               ch_oe,
  output logic               eoa_flag,
  output logic               mce_flag,
  output logic               irq,
  output logic [NG-1:0]      grp_done,
  output logic [NG*(8+MCODE_MAX)-1:0] grp_count
);
  localparam int CW = 8 + MCODE_MAX;

  logic          tick, running, in_high, launch, pulse_end, finishing, start_q;
  logic [NG-1:0] done_vec, hit_vec, term_vec;
  logic [CODEW-1:0] code_eff;
  logic [CW:0]   limit_w;
  logic [CW-1:0] limit;
  logic          finish_cond;

  assign code_eff = (max_code > CODEW'(MCODE_MAX)) ? CODEW'(MCODE_MAX) : max_code;
  assign limit_w  = ((CW+1)'(1) << (8 + int'(code_eff))) - (CW+1)'(1);
  assign limit    = limit_w[CW-1:0];

  cts_prescaler #(.DIVW(DIVW)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(running), .div(pg_div), .tick(tick)
  );

  cts_phase_ctrl #(.LENW(LENW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set),
    .sync_mode(sync_mode), .sync_pol(sync_pol), .sync_in(sync_in),
    .tick(tick), .hi_len(hi_len), .lo_len(lo_len),
    .no_groups(~|grp_en), .finish_cond(finish_cond),
    .start_q(start_q), .running(running), .in_high(in_high),
    .launch(launch), .pulse_end(pulse_end), .finishing(finishing)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    cts_group_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clear(launch), .step(pulse_end),
      .grp_on(grp_en[g]), .cmp(cmp_in[g]), .limit(limit),
      .cnt(grp_count[g*CW +: CW]), .done(done_vec[g]), .hit(hit_vec[g])
    );
    assign term_vec[g] = !grp_en[g] || done_vec[g] || cmp_in[g];
  end

  assign finish_cond = (|hit_vec) || (&term_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoa_flag <= 1'b0;
      mce_flag <= 1'b0;
    end else begin
      eoa_flag <= finishing || (eoa_flag && !flag_clr[0]);
      mce_flag <= (pulse_end && |hit_vec) || (mce_flag && !flag_clr[1]);
    end
  end

  assign busy     = start_q;
  assign ch_level = in_high;
  assign ch_oe    = running || !idle_float;
  assign irq      = (eoa_flag && eoa_ie) || (mce_flag && mce_ie);
  assign grp_done = done_vec & ~{NG{mce_flag}};

  // R4: a max-count error ends the acquisition on the following cycle
  p_mce_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mce_flag) && en) |=> (eoa_flag && !busy));

  // R10: the channel is never driven high without its output enabled
  p_level_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_level |-> ch_oe);
endmodule

// File: tb/cap_acq_seq_bench.sv
module cap_acq_seq_bench;
  localparam int NG = 4;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, start_set = 1'b0;
  logic [3:0] hi_len = '0, lo_len = '0;
  logic [2:0] pg_div = '0, max_code = '0;
  logic sync_mode = 1'b0, sync_pol = 1'b0, sync_in = 1'b0, idle_float = 1'b0;
  logic eoa_ie = 1'b0, mce_ie = 1'b0;
  logic [1:0] flag_clr = '0;
  logic [NG-1:0] grp_en = '0, cmp_in;
  logic busy, ch_level, ch_oe, eoa_flag, mce_flag, irq;
  logic [NG-1:0] grp_done;
  logic [NG*CW-1:0] grp_count;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cap_acq_seq u_cap_acq_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set),
    .hi_len(hi_len), .lo_len(lo_len), .pg_div(pg_div), .max_code(max_code),
    .sync_mode(sync_mode), .sync_pol(sync_pol), .sync_in(sync_in),
    .idle_float(idle_float), .eoa_ie(eoa_ie), .mce_ie(mce_ie),
    .flag_clr(flag_clr), .grp_en(grp_en), .cmp_in(cmp_in),
    .busy(busy), .ch_level(ch_level), .ch_oe(ch_oe), .eoa_flag(eoa_flag),
    .mce_flag(mce_flag), .irq(irq), .grp_done(grp_done), .grp_count(grp_count)
  );

  // Sensor model: group g trips once the bench has seen tgt[g] high phases.
  logic [7:0] tgt [NG];
  logic mon_clr = 1'b1;
  int seen = 0, hi_run = 0, lo_run = 0;
  logic prev_lvl = 1'b0, fell_once = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      seen = 0; hi_run = 0; lo_run = 0; prev_lvl = 1'b0; fell_once = 1'b0;
    end else begin
      if (ch_level && !prev_lvl) seen = seen + 1;
      if (!ch_level && prev_lvl) fell_once = 1'b1;
      if (ch_level && seen == 1) hi_run = hi_run + 1;
      if (!ch_level && fell_once && seen == 1 && busy) lo_run = lo_run + 1;
      prev_lvl = ch_level;
    end
    for (int g = 0; g < NG; g++)
      cmp_in[g] = (tgt[g] != 0) && (seen >= int'(tgt[g]));
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 60000) begin @(negedge clk); n++; end
    if (busy) check("R6 timeout", 1, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic setup(input logic [3:0] h, input logic [3:0] l, input logic [2:0] d,
                       input logic [2:0] c, input logic [3:0] ge,
                       input logic [7:0] t0, input logic [7:0] t1,
                       input logic [7:0] t2, input logic [7:0] t3);
    @(negedge clk);
    hi_len = h; lo_len = l; pg_div = d; max_code = c; grp_en = ge;
    tgt[0] = t0; tgt[1] = t1; tgt[2] = t2; tgt[3] = t3;
    mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  function automatic int cnt_of(input int g);
    return int'(grp_count[g*CW +: CW]);
  endfunction

  typedef struct packed {
    logic [3:0] hi; logic [3:0] lo; logic [2:0] dv; logic [2:0] code;
    logic [3:0] ge; logic [7:0] t0; logic [7:0] t1; logic [7:0] t2; logic [7:0] t3;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{hi:4'd0,  lo:4'd0,  dv:3'd0, code:3'd0, ge:4'hF, t0:8'd1, t1:8'd2, t2:8'd3, t3:8'd4},
    '{hi:4'd2,  lo:4'd1,  dv:3'd1, code:3'd0, ge:4'h5, t0:8'd5, t1:8'd9, t2:8'd7, t3:8'd3},
    '{hi:4'd15, lo:4'd15, dv:3'd0, code:3'd0, ge:4'h8, t0:8'd1, t1:8'd1, t2:8'd1, t3:8'd2},
    '{hi:4'd0,  lo:4'd0,  dv:3'd0, code:3'd0, ge:4'h3, t0:8'd0, t1:8'd3, t2:8'd1, t3:8'd1},
    '{hi:4'd1,  lo:4'd0,  dv:3'd2, code:3'd1, ge:4'h2, t0:8'd1, t1:8'd0, t2:8'd1, t3:8'd1},
    '{hi:4'd3,  lo:4'd2,  dv:3'd3, code:3'd0, ge:4'hF, t0:8'd2, t1:8'd2, t2:8'd2, t3:8'd2}
  };

  initial begin
    for (int g = 0; g < NG; g++) tgt[g] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R6 reset busy", int'(busy), 0);
    check("R10 reset oe", int'(ch_oe), 1);
    check("R10 reset level", int'(ch_level), 0);
    check("R7 reset flags", int'({eoa_flag, mce_flag}), 0);
    check("R8 reset irq", int'(irq), 0);
    check("R3 reset count", int'(grp_count), 0);
    idle_float = 1'b1; @(negedge clk);
    check("R10 idle float", int'(ch_oe), 0);
    en = 1'b1;

    // Table walk
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic int lim = (1 << (8 + int'(v.code))) - 1;
      automatic logic [7:0] ts [NG] = '{v.t0, v.t1, v.t2, v.t3};
      automatic bit exp_mce = 1'b0;
      automatic bit multi = 1'b0;
      automatic int exp_done = 0;
      clear_flags();
      setup(v.hi, v.lo, v.dv, v.code, v.ge, v.t0, v.t1, v.t2, v.t3);
      for (int g = 0; g < NG; g++) if (v.ge[g]) begin
        if (ts[g] == 0) exp_mce = 1'b1;
        if (ts[g] != 1) multi = 1'b1;
      end
      for (int g = 0; g < NG; g++)
        if (v.ge[g] && ts[g] != 0 && !exp_mce) exp_done |= (1 << g);
      pulse_start();
      @(negedge clk);
      check("R10 oe while running", int'(ch_oe), 1);
      wait_idle();
      for (int g = 0; g < NG; g++)
        check(v.ge[g] ? (ts[g] == 0 ? "R4 limit count" : "R3 trip count") : "R12 disabled count",
              cnt_of(g), v.ge[g] ? (ts[g] == 0 ? lim : int'(ts[g])) : 0);
      check("R6 eoa", int'(eoa_flag), 1);
      check("R4 mce", int'(mce_flag), int'(exp_mce));
      check("R9 done bits", int'(grp_done), exp_done);
      check("R1 high length", hi_run, (int'(v.hi) + 1) << v.dv);
      if (multi) check("R2 low length", lo_run, (int'(v.lo) + 1) << v.dv);
    end
    idle_float = 1'b0;

    // Flags and interrupt
    clear_flags();
    setup(0, 0, 0, 0, 4'h1, 0, 1, 1, 1);
    pulse_start(); wait_idle();
    check("R4 mce set", int'(mce_flag), 1);
    eoa_ie = 0; mce_ie = 0; @(negedge clk);
    check("R8 irq masked", int'(irq), 0);
    eoa_ie = 1; @(negedge clk);
    check("R8 irq eoa", int'(irq), 1);
    flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
    check("R7 eoa cleared", int'(eoa_flag), 0);
    check("R7 mce kept", int'(mce_flag), 1);
    check("R8 irq after eoa clear", int'(irq), 0);
    mce_ie = 1; @(negedge clk);
    check("R8 irq mce", int'(irq), 1);
    flag_clr = 2'b10; @(negedge clk); flag_clr = 2'b00;
    check("R7 mce cleared", int'(mce_flag), 0);
    eoa_ie = 0; mce_ie = 0;

    // Sync falling edge
    sync_mode = 1; sync_pol = 0; sync_in = 0;
    setup(0, 0, 0, 0, 4'h1, 1, 1, 1, 1);
    pulse_start();
    repeat (10) @(negedge clk);
    check("R5 waits", int'(busy) * 100 + seen, 100);
    sync_in = 1; repeat (6) @(negedge clk);
    check("R5 rise ignored pol0", seen, 0);
    sync_in = 0; wait_idle();
    check("R5 falling launch", cnt_of(0), 1);

    // Sync high level
    sync_pol = 1; sync_in = 0;
    setup(0, 0, 0, 0, 4'h1, 2, 1, 1, 1);
    pulse_start();
    repeat (8) @(negedge clk);
    check("R5 level wait", seen, 0);
    sync_in = 1; wait_idle();
    check("R5 level launch", cnt_of(0), 2);
    sync_mode = 0; sync_in = 0;

    // No groups enabled
    clear_flags();
    setup(0, 0, 0, 0, 4'h0, 1, 1, 1, 1);
    pulse_start(); wait_idle();
    check("R12 empty eoa", int'(eoa_flag), 1);
    check("R12 empty pulses", seen, 0);

    // Code 7 clamps to 16383
    clear_flags();
    setup(0, 0, 0, 7, 4'h1, 0, 1, 1, 1);
    pulse_start(); wait_idle();
    check("R4 clamp count", cnt_of(0), 16383);
    check("R4 clamp mce", int'(mce_flag), 1);

    // Abort and ignored start
    clear_flags();
    setup(0, 0, 0, 0, 4'h1, 0, 1, 1, 1);
    pulse_start();
    repeat (20) @(negedge clk);
    en = 0; @(negedge clk);
    check("R11 abort busy", int'(busy), 0);
    check("R11 abort level", int'(ch_level), 0);
    start_set = 1; @(negedge clk); start_set = 0;
    en = 1; repeat (3) @(negedge clk);
    check("R11 start ignored", int'(busy), 0);
    check("R11 no eoa", int'(eoa_flag), 0);

    summary();
    $finish;
  end
endmodule